// File: doc/BRIEF.md
# Per-Set Pseudo-LRU Victim Tracker Array

This block keeps replacement state for a 4-way set-associative translation cache with 64 sets. Each set owns a small binary-tree pseudo-LRU tracker. When a lookup hits, the surrounding logic presents the set index and the way that hit. Only that set's tracker moves, so that it points away from the way just used.

The update enables come from one shared two-level decoder. The high half of the index selects one of eight groups, and the low half selects one member inside that group. The result is a one-hot vector with one bit per tracker. No tracker compares its own number against the index.

A separate read port takes any set index and returns, combinationally, the way that the set's tracker names as the next victim. The miss logic uses that way when it refills the set.

Top module: `plru_set_array`

## Requirements
- R1: The array holds 64 independent trackers addressed by a 6-bit set index. Each set's victim depends only on the hits to that set since reset.
- R2: An accepted hit changes only the tracker of the hit set. The victims of the other 63 sets are unchanged afterwards.
- R3: Update enables come from a two-level one-hot decode: index bits [5:3] select a group of eight and bits [2:0] select a member. While hit_valid is high exactly one enable is active, at position hit_set.
- R4: Each tracker has three bits: a root, a leaf for ways {0,1} and a leaf for ways {2,3}. A root of 0 selects the {0,1} pair and the victim is that leaf's value (0 or 1). A root of 1 selects the {2,3} pair and the victim is 2 plus that leaf's value.
- R5: A hit on way w sets the root to the inverse of w[1] and sets the leaf of w's pair to the inverse of w[0]. The other leaf is left alone. As a result the set's victim is never w straight after the hit.
- R6: While hit_valid is low, no tracker changes, whatever hit_set and hit_way carry.
- R7: A synchronous active-high reset clears every tracker, so every set's victim is way 0. Reset takes priority over a hit presented in the same cycle.
- R8: victim_way follows rd_set combinationally. An update becomes visible only after the clock edge that takes it, so a read of the hit set in the same cycle returns the value from before the hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 1 | A hit is presented this cycle |
| hit_set | input | 6 | Set index of the hit |
| hit_way | input | 2 | Way that hit |
| rd_set | input | 6 | Set index for the victim read |
| victim_way | output | 2 | Victim way of set rd_set |

## Verification
An update and a victim read of the same set can fall in the same cycle. The bench provokes this by driving rd_set equal to hit_set while hit_valid is high, for every set and every way. It expects the pre-update victim before the edge and the recomputed victim after it. After every hit, the bench also reads all 64 sets to confirm that the decoder enabled exactly one tracker.

// File: rtl/plru_set_array.sv
module plru_set_array #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_valid,
  input  logic [IDX_W-1:0] hit_set,
  input  logic [1:0]       hit_way,
  input  logic [IDX_W-1:0] rd_set,
  output logic [1:0]       victim_way
);
  localparam int LO_W = IDX_W / 2;
  localparam int HI_W = IDX_W - LO_W;
  localparam int LO_N = 1 << LO_W;
  localparam int HI_N = 1 << HI_W;
  localparam int SETS = 1 << IDX_W;

  // tree layout: [2] root, [1] leaf of ways {0,1}, [0] leaf of ways {2,3}
  function automatic logic [1:0] pick(input logic [2:0] t);
    return t[2] ? {1'b1, t[0]} : {1'b0, t[1]};
  endfunction

  logic [HI_N-1:0]      grp_sel;
  logic [LO_N-1:0]      mbr_sel;
  logic [SETS-1:0]      upd_en;
  logic [SETS-1:0][2:0] tree_q;
  logic [2:0]           rd_tree;

  assign grp_sel = hit_valid ? ({{(HI_N-1){1'b0}}, 1'b1} << hit_set[IDX_W-1:LO_W]) : '0;
  assign mbr_sel = {{(LO_N-1){1'b0}}, 1'b1} << hit_set[LO_W-1:0];

  for (genvar h = 0; h < HI_N; h++) begin : g_grp
    for (genvar l = 0; l < LO_N; l++) begin : g_mbr
      assign upd_en[h*LO_N+l] = grp_sel[h] & mbr_sel[l];
    end
  end

  for (genvar i = 0; i < SETS; i++) begin : g_trk
    logic [2:0] t_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        t_q <= '0;
      end else if (upd_en[i]) begin
        t_q[2] <= ~hit_way[1];
        if (hit_way[1]) t_q[0] <= ~hit_way[0];
        else            t_q[1] <= ~hit_way[0];
      end
    end
    assign tree_q[i] = t_q;
  end

  assign rd_tree    = tree_q[rd_set];
  assign victim_way = pick(rd_tree);

  a_r3_one_enable: assert property (@(posedge clk) disable iff (rst)
    hit_valid |-> ($countones(upd_en) == 1 && upd_en[hit_set]));

  a_r3_quiet_decode: assert property (@(posedge clk) disable iff (rst)
    !hit_valid |-> upd_en == '0);

  a_r5_points_away: assert property (@(posedge clk) disable iff (rst)
    hit_valid |=> pick(tree_q[$past(hit_set)]) != $past(hit_way));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !hit_valid |=> $stable(tree_q));
endmodule

// File: tb/sim_plru_set_array.sv
`timescale 1ns/1ps
module sim_plru_set_array;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hit_valid = 1'b0;
  logic [5:0] hit_set = '0;
  logic [1:0] hit_way = '0;
  logic [5:0] rd_set = '0;
  logic [1:0] victim_way;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic m_root [64];
  logic m_lo   [64];
  logic m_hi   [64];

  plru_set_array u0 (
    .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_set(hit_set),
    .hit_way(hit_way), .rd_set(rd_set), .victim_way(victim_way)
  );

  always #4 clk = ~clk;

  function automatic logic [1:0] exp_vic(input int s);
    return m_root[s] ? {1'b1, m_hi[s]} : {1'b0, m_lo[s]};
  endfunction

  task automatic model_clear();
    for (int s = 0; s < 64; s++) begin
      m_root[s] = 1'b0; m_lo[s] = 1'b0; m_hi[s] = 1'b0;
    end
  endtask

  task automatic model_hit(input int s, input logic [1:0] w);
    m_root[s] = ~w[1];
    if (w[1]) m_hi[s] = ~w[0];
    else      m_lo[s] = ~w[0];
  endtask

  task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s set=%0d got=%0d exp=%0d", req, rd_set, got, exp);
    end
  endtask

  task automatic sweep(input string req);
    for (int s = 0; s < 64; s++) begin
      rd_set = 6'(s);
      #0.1;
      chk(req, victim_way, exp_vic(s));
    end
  endtask

  task automatic do_hit(input int s, input logic [1:0] w, input bit same_read);
    @(negedge clk);
    hit_valid = 1'b1; hit_set = 6'(s); hit_way = w;
    if (same_read) begin
      rd_set = 6'(s);
      #1;
      chk("R8 pre-edge", victim_way, exp_vic(s));
    end
    @(negedge clk);
    hit_valid = 1'b0;
    model_hit(s, w);
    if (same_read) begin
      #0.1;
      chk("R8 post-edge", victim_way, exp_vic(s));
      chk("R5 away", (victim_way == w) ? 2'b11 : 2'b00, 2'b00);
    end
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7: reset state
    sweep("R7 reset");

    // R1 R2 R4 R5 R8: every set, every way, full sweep after each hit
    for (int s = 0; s < 64; s++) begin
      for (int w = 0; w < 4; w++) begin
        do_hit(s, 2'(w), 1'b1);
        sweep("R2 isolation");
      end
    end

    // R6: hit_valid low with busy inputs
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      hit_set = 6'(k * 7 + 3); hit_way = 2'(k);
    end
    @(negedge clk);
    sweep("R6 hold");

    // R4/R5: pair-leaf retention sequences on a few sets
    for (int s = 0; s < 64; s += 9) begin
      do_hit(s, 2'd0, 1'b0);
      do_hit(s, 2'd3, 1'b0);
      do_hit(s, 2'd2, 1'b0);
      do_hit(s, 2'd1, 1'b0);
      rd_set = 6'(s); #0.1;
      chk("R4 decode", victim_way, exp_vic(s));
    end

    // R1/R3: pseudo-random hit stream
    begin
      logic [7:0] lf = 8'hA5;
      for (int k = 0; k < 600; k++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        do_hit(int'(lf[5:0]), lf[7:6], 1'b0);
      end
      sweep("R3 random");
    end

    // R7: reset wins over a simultaneous hit
    @(negedge clk);
    rst = 1'b1; hit_valid = 1'b1; hit_set = 6'd12; hit_way = 2'd0;
    @(negedge clk);
    rst = 1'b0; hit_valid = 1'b0;
    model_clear();
    sweep("R7 reset priority");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule